// File: doc/BRIEF.md
# Processor Idle Clock Gate

This block provides the idle mode of a processor by gating its clock. Software asks for the clock to stop by writing a 1 to the processor bit of a clear register. The block does not stop the clock at once. It waits until the core reports that the instruction in flight has retired, and only then drops the clock-enable. A 1 written to the same bit of a set register restarts the clock, and so does a reset. While the core sleeps, any unmasked fast or normal interrupt request restarts the clock in hardware, with no software involved. A status word reports at any time whether the processor clock is running.

The block runs on the always-on bus clock. This keeps the bus side live for other masters while the core is stopped. The enable output comes straight from a flip-flop, so the downstream gating cell only ever sees a change just after a bus-clock edge.

Top module: `pidle_gate`

## Requirements
- R1: When reset is released, `proc_clk_en` is 1 and bit PROC_BIT of `status_o` reads 1. All other status bits read 0 at all times. An active reset restarts a stopped clock on the next edge.
- R2: A cycle with `dis_wr`=1 and `dis_data[PROC_BIT]`=1, while the clock runs, starts a pending stop. `proc_clk_en` stays 1 until the first cycle in which `insn_done` is 1. It then falls at that edge.
- R3: While the clock runs and no stop is pending, `insn_done` has no effect on `proc_clk_en`.
- R4: While stopped, if any bit of `fiq_req & fiq_mask` is 1, `proc_clk_en` returns to 1 at the next edge.
- R5: While stopped, if any bit of `irq_req & irq_mask` is 1, `proc_clk_en` returns to 1 at the next edge.
- R6: Interrupt requests whose mask bit is 0 do not restart a stopped clock, and neither does `insn_done`.
- R7: A cycle with `en_wr`=1 and `en_data[PROC_BIT]`=1 restarts a stopped clock at the next edge. In the same way it cancels a pending stop, so a later `insn_done` does not stop the clock.
- R8: An unmasked fast or normal interrupt during a pending stop cancels the stop, so a later `insn_done` does not stop the clock.
- R9: If set and clear writes of the processor bit occur in the same cycle, the set write wins and the clock keeps running.
- R10: A write whose PROC_BIT is 0 has no effect on either register, whatever its other bits hold.
- R11: If `insn_done` and an unmasked interrupt occur in the same cycle during a pending stop, the interrupt wins and the clock keeps running.
- R12: `proc_clk_en` is a register output, equal to bit PROC_BIT of `status_o`. It changes only at an edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe of the clock-set register |
| en_data | input | DATA_W | Write data of the clock-set register |
| dis_wr | input | 1 | Write strobe of the clock-clear register |
| dis_data | input | DATA_W | Write data of the clock-clear register |
| status_o | output | DATA_W | Status word; bit PROC_BIT is 1 while the processor clock runs |
| fiq_req | input | NUM_FIQ | Fast interrupt request lines |
| fiq_mask | input | NUM_FIQ | Per-line fast interrupt enables |
| irq_req | input | NUM_IRQ | Normal interrupt request lines |
| irq_mask | input | NUM_IRQ | Per-line normal interrupt enables |
| insn_done | input | 1 | Core reports its current instruction has retired |
| proc_clk_en | output | 1 | Registered enable for the processor clock gate |

## Verification
The bench targets the window between the clear write and instruction retirement. A design that stopped at once would drop the enable one cycle early. A design that ignored a cancel in that window would stop after the next `insn_done` although software or an interrupt had asked for the clock. The bench also checks that masked requests leave the core asleep, since a design that skipped the mask would wake on noise. It drives set and clear together, and a simultaneous retire and interrupt, to expose a wrong priority: there the clock would stop when it should not. Writes carrying every other data bit but not the processor bit show whether the decode looks at the wrong bit.

// File: rtl/pidle_pkg.sv
package pidle_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_IDLE = 2'd2
    } gate_state_t;

    typedef struct packed {
        logic turn_on;
        logic turn_off;
    } sw_cmd_t;

    typedef struct packed {
        gate_state_t state;
        logic        clk_en;
    } gate_regs_t;

    localparam gate_regs_t GATE_RESET = '{state: ST_RUN, clk_en: 1'b1};

    // Next-state rule: set and wake beat everything, retire completes a pending stop.
    function automatic gate_state_t step_state(gate_state_t cur, sw_cmd_t cmd,
                                               logic wake, logic done);
        gate_state_t nxt;
        nxt = cur;
        unique case (cur)
            ST_RUN: begin
                if (cmd.turn_off) nxt = ST_PEND;
            end
            ST_PEND: begin
                if (cmd.turn_on || wake) nxt = ST_RUN;
                else if (done)           nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd.turn_on || wake) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
        return nxt;
    endfunction

    function automatic logic runs_in(gate_state_t s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/pidle_cmd.sv
module pidle_cmd #(
    parameter int DATA_W   = 8,
    parameter int PROC_BIT = 0
) (
    input  logic                 en_wr,
    input  logic [DATA_W-1:0]    en_data,
    input  logic                 dis_wr,
    input  logic [DATA_W-1:0]    dis_data,
    output pidle_pkg::sw_cmd_t   cmd
);
    logic set_hit;
    logic clr_hit;
    logic unused_bits;

    assign set_hit = en_wr  & en_data[PROC_BIT];
    assign clr_hit = dis_wr & dis_data[PROC_BIT];

    // Set wins over clear in the same cycle.
    always_comb begin
        cmd.turn_on  = set_hit;
        cmd.turn_off = clr_hit & ~set_hit;
    end

    assign unused_bits = ^{en_data, dis_data};

endmodule

// File: rtl/pidle_wake.sv
module pidle_wake #(
    parameter int NUM_FIQ = 2,
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_FIQ-1:0] fiq_req,
    input  logic [NUM_FIQ-1:0] fiq_mask,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    output logic               wake_fast,
    output logic               wake_norm,
    output logic               wake
);
    logic [NUM_FIQ-1:0] fiq_hit;
    logic [NUM_IRQ-1:0] irq_hit;

    for (genvar f = 0; f < NUM_FIQ; f++) begin : g_fiq
        assign fiq_hit[f] = fiq_req[f] & fiq_mask[f];
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_hit[i] = irq_req[i] & irq_mask[i];
    end

    assign wake_fast = |fiq_hit;
    assign wake_norm = |irq_hit;
    assign wake      = wake_fast | wake_norm;

endmodule

// File: rtl/pidle_fsm.sv
module pidle_fsm
    import pidle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sw_cmd_t     cmd,
    input  logic        wake,
    input  logic        insn_done,
    output gate_state_t state,
    output logic        clk_en
);
    gate_regs_t regs_q;
    gate_regs_t regs_d;

    always_comb begin
        regs_d.state  = step_state(regs_q.state, cmd, wake, insn_done);
        regs_d.clk_en = runs_in(regs_d.state);
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= GATE_RESET;
        else     regs_q <= regs_d;
    end

    assign state  = regs_q.state;
    assign clk_en = regs_q.clk_en;

    AST_RESET_RUNS: assert property (@(posedge clk)
        rst |=> clk_en); // R1

    AST_STOP_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> ($past(insn_done) && $past(state) == ST_PEND)); // R2

    AST_RUN_IGNORES_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !cmd.turn_off) |=> (state == ST_RUN)); // R3

    AST_WAKE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && wake) |=> (clk_en && state == ST_RUN)); // R8

    AST_MASKED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !wake && !cmd.turn_on) |=> !clk_en); // R6

    AST_SET_RUNS: assert property (@(posedge clk) disable iff (rst)
        cmd.turn_on |=> (state == ST_RUN)); // R9

    AST_NO_PENDING_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !clk_en); // R12

endmodule

// File: rtl/pidle_gate.sv
module pidle_gate
    import pidle_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PROC_BIT = 0,
    parameter int NUM_FIQ  = 2,
    parameter int NUM_IRQ  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr,
    input  logic [DATA_W-1:0]  en_data,
    input  logic               dis_wr,
    input  logic [DATA_W-1:0]  dis_data,
    output logic [DATA_W-1:0]  status_o,
    input  logic [NUM_FIQ-1:0] fiq_req,
    input  logic [NUM_FIQ-1:0] fiq_mask,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               insn_done,
    output logic               proc_clk_en
);
    sw_cmd_t     cmd;
    logic        wake_fast;
    logic        wake_norm;
    logic        wake;
    gate_state_t state;
    logic        clk_en;

    pidle_cmd #(.DATA_W(DATA_W), .PROC_BIT(PROC_BIT)) u_cmd (
        .en_wr   (en_wr),
        .en_data (en_data),
        .dis_wr  (dis_wr),
        .dis_data(dis_data),
        .cmd     (cmd)
    );

    pidle_wake #(.NUM_FIQ(NUM_FIQ), .NUM_IRQ(NUM_IRQ)) u_wake (
        .fiq_req  (fiq_req),
        .fiq_mask (fiq_mask),
        .irq_req  (irq_req),
        .irq_mask (irq_mask),
        .wake_fast(wake_fast),
        .wake_norm(wake_norm),
        .wake     (wake)
    );

    pidle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wake     (wake),
        .insn_done(insn_done),
        .state    (state),
        .clk_en   (clk_en)
    );

    always_comb begin
        status_o           = '0;
        status_o[PROC_BIT] = clk_en;
    end

    assign proc_clk_en = clk_en;

    AST_FAST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && wake_fast) |=> proc_clk_en); // R4

    AST_NORM_WAKE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && wake_norm) |=> proc_clk_en); // R5

    AST_PEND_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PEND && (wake || cmd.turn_on)) |=> proc_clk_en); // R11

    AST_DONE_NEEDED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PEND && !insn_done) |=> proc_clk_en); // R2

    AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !en_data[PROC_BIT] && !wake) |=> !proc_clk_en); // R10

endmodule

// File: tb/sim_pidle_gate.sv
module sim_pidle_gate;
    localparam int DATA_W   = 8;
    localparam int PROC_BIT = 0;
    localparam int NUM_FIQ  = 2;
    localparam int NUM_IRQ  = 4;
    localparam int NVEC     = 29;

    logic               clk = 1'b0;
    logic               rst;
    logic               en_wr, dis_wr, insn_done;
    logic [DATA_W-1:0]  en_data, dis_data, status_o;
    logic [NUM_FIQ-1:0] fiq_req, fiq_mask;
    logic [NUM_IRQ-1:0] irq_req, irq_mask;
    logic               proc_clk_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pidle_gate #(.DATA_W(DATA_W), .PROC_BIT(PROC_BIT),
                 .NUM_FIQ(NUM_FIQ), .NUM_IRQ(NUM_IRQ)) u0 (
        .clk(clk), .rst(rst),
        .en_wr(en_wr), .en_data(en_data),
        .dis_wr(dis_wr), .dis_data(dis_data),
        .status_o(status_o),
        .fiq_req(fiq_req), .fiq_mask(fiq_mask),
        .irq_req(irq_req), .irq_mask(irq_mask),
        .insn_done(insn_done),
        .proc_clk_en(proc_clk_en)
    );

    // Field layout: en_wr en_val dis_wr dis_val fiq[2] fmask[2] irq[4] imask[4] done exp
    function automatic logic [17:0] mk(logic ew, logic ev, logic dw, logic dv,
                                       logic [1:0] fq, logic [1:0] fm,
                                       logic [3:0] iq, logic [3:0] im,
                                       logic dn, logic ex);
        return {ew, ev, dw, dv, fq, fm, iq, im, dn, ex};
    endfunction

    localparam logic [17:0] VEC [NVEC] = '{
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R2 clear -> pending, still on
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,0,1), // R2 waits for retire
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,0), // R2 retire -> off
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,0,0), // R6 stays off
        mk(0,0,0,0,2'b00,2'b00,4'h1,4'h0,0,0), // R6 masked irq
        mk(0,0,0,0,2'b01,2'b10,4'h0,4'h0,0,0), // R6 masked fiq
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,0), // R6 retire while stopped
        mk(0,0,0,0,2'b01,2'b01,4'h0,4'h0,0,1), // R4 fast wake
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1), // R3 retire while running
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R8 clear
        mk(0,0,0,0,2'b00,2'b00,4'h8,4'h8,0,1), // R8 irq cancels
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1), // R8 retire after cancel
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R5 clear
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,0), // R5 stop
        mk(0,0,0,0,2'b00,2'b00,4'h2,4'h2,0,1), // R5 normal wake
        mk(0,0,1,0,2'b00,2'b00,4'h0,4'h0,0,1), // R10 clear without proc bit
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1), // R10 retire, still running
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R10 clear
        mk(1,0,0,0,2'b00,2'b00,4'h0,4'h0,0,1), // R10 set without proc bit
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,0), // R10 stop not cancelled
        mk(1,1,0,0,2'b00,2'b00,4'h0,4'h0,0,1), // R7 set restarts
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R7 clear
        mk(1,1,0,0,2'b00,2'b00,4'h0,4'h0,0,1), // R7 set cancels pending
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1), // R7 retire after cancel
        mk(0,0,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R11 clear
        mk(0,0,0,0,2'b10,2'b10,4'h0,4'h0,1,1), // R11 retire + fiq together
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1), // R11 retire later
        mk(1,1,1,1,2'b00,2'b00,4'h0,4'h0,0,1), // R9 set + clear together
        mk(0,0,0,0,2'b00,2'b00,4'h0,4'h0,1,1)  // R9 retire, still running
    };

    localparam int VREQ [NVEC] = '{2,2,2,6,6,6,6,4,3,8,8,8,5,5,5,10,10,10,10,10,
                                   7,7,7,7,11,11,11,9,9};

    task automatic idle_inputs();
        en_wr = 1'b0; en_data = '0; dis_wr = 1'b0; dis_data = '0;
        fiq_req = '0; fiq_mask = '0; irq_req = '0; irq_mask = '0;
        insn_done = 1'b0;
    endtask

    task automatic check(string req, logic [DATA_W-1:0] stat, logic en,
                         logic [DATA_W-1:0] exp_stat, logic exp_en);
        checks++;
        if (stat !== exp_stat || en !== exp_en) begin
            fails++;
            $display("FAIL %s: actual en=%0b status=%h expected en=%0b status=%h",
                     req, en, stat, exp_en, exp_stat);
        end
    endtask

    function automatic logic [DATA_W-1:0] stat_of(logic on);
        logic [DATA_W-1:0] s;
        s = '0;
        s[PROC_BIT] = on;
        return s;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset state", status_o, proc_clk_en, stat_of(1'b1), 1'b1);

        for (int k = 0; k < NVEC; k++) begin
            logic [17:0] v;
            string tag;
            v = VEC[k];
            @(negedge clk);
            en_wr     = v[17];
            en_data   = v[16] ? stat_of(1'b1) : ~stat_of(1'b1);
            dis_wr    = v[15];
            dis_data  = v[14] ? stat_of(1'b1) : ~stat_of(1'b1);
            fiq_req   = v[13:12];
            fiq_mask  = v[11:10];
            irq_req   = v[9:6];
            irq_mask  = v[5:2];
            insn_done = v[1];
            @(posedge clk);
            #2;
            tag = $sformatf("R%0d vector %0d", VREQ[k], k);
            check(tag, status_o, proc_clk_en, stat_of(v[0]), v[0]);
            check($sformatf("R12 vector %0d status matches enable", k),
                  status_o, proc_clk_en, stat_of(proc_clk_en), v[0]);
        end

        // Reset while stopped restarts the clock (R1)
        @(negedge clk);
        idle_inputs();
        dis_wr = 1'b1; dis_data = stat_of(1'b1);
        @(negedge clk);
        idle_inputs();
        insn_done = 1'b1;
        @(negedge clk);
        idle_inputs();
        #1;
        check("R2 stopped before reset", status_o, proc_clk_en, stat_of(1'b0), 1'b0);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1 reset wakes", status_o, proc_clk_en, stat_of(1'b1), 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // Retire during run with full masks but no requests (R3)
        insn_done = 1'b1; fiq_mask = '1; irq_mask = '1;
        @(posedge clk);
        #2;
        check("R3 retire with masks set", status_o, proc_clk_en, stat_of(1'b1), 1'b1);

        @(negedge clk);
        idle_inputs();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule